// File: doc/BRIEF.md
# Key-Gated Configuration Register File

This block is a small register file on a byte-wide bus with an 8-bit address, write data, a write strobe, a read strobe and registered read data. Six of its registers hold settings that must not change by accident, so each of them takes a write only when an unlock register already holds the right code. One code opens the oscillator setup register. A second code opens the five system setup registers.

A granted write uses up the unlock: the hardware clears the key register in the same cycle, so every change to a guarded register needs its own unlock. The key register is write-only. Sixteen ordinary scratch registers sit at the bottom of the address map and take writes at any time, whatever the key holds. Three control bits from the guarded registers are brought out as ports for the surrounding logic.

Top module: `cfgk_regfile`

## Requirements
- R1: After reset, guarded register 0x1C reads 0x00, 0x21 reads 0xF0, 0x27 reads 0x80, and 0x20, 0x26 and 0x30 read 0x00. `osc_rc_autoswitch` is 0, `sw_threshold` is 4'hF and `backup_bus_en` is 1.
- R2: A write to 0x1C changes it only if the key register holds 0xA1 at that write. The code 0x9D does not unlock it.
- R3: A write to 0x20, 0x21, 0x26, 0x27 or 0x30 changes it only if the key register holds 0x9D at that write. The code 0xA1 does not unlock them.
- R4: A granted write to a guarded register sets the key register to 0x00. A second guarded write with no new unlock is ignored.
- R5: A guarded write made with a wrong or empty key is ignored and leaves the key register as it was. A later guarded write that matches the kept code still succeeds.
- R6: Writing 0xA1 or 0x9D to the key register (address 0x1F) stores that value. Writing any other value stores 0x00.
- R7: A read of address 0x1F returns 0x00 whatever the key holds.
- R8: Scratch registers 0x00 to 0x0F are written whatever the key holds, and writing them does not clear the key.
- R9: `bus_rdata` takes the addressed register's value on the clock edge where `bus_rd` is high. Unmapped addresses read 0x00. `bus_rdata` holds its value while `bus_rd` is low.
- R10: `osc_rc_autoswitch` is bit 4 of 0x1C, `sw_threshold` is bits 7:4 of 0x21 and `backup_bus_en` is bit 7 of 0x27. Each changes on the same edge as its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| osc_rc_autoswitch | output | 1 | Enables the switch to the RC oscillator in backup power |
| sw_threshold | output | 4 | Supply switchover threshold code |
| backup_bus_en | output | 1 | Keeps the bus interface alive in backup power |

## Verification
The key register cannot be read back, so its contents can only be inferred from which guarded writes later take effect. The hardest cases are those where the key must be shown unchanged: after a rejected guarded write, after a write of the other code, and after scratch writes.

The stimulus loads one code and then makes a guarded write that does not match it. It then makes a matching guarded write and reads the register back to show the code was still there. A further write without a new unlock shows the code was consumed.

// File: rtl/cfgk_pkg.sv
package cfgk_pkg;

    localparam int          NUM_PROT  = 6;
    localparam logic [7:0]  KEY_ADDR  = 8'h1F;
    localparam logic [7:0]  CODE_OSC  = 8'hA1;
    localparam logic [7:0]  CODE_SYS  = 8'h9D;

    localparam int IDX_OSC    = 0;
    localparam int IDX_THRESH = 2;
    localparam int IDX_BKUP   = 4;

    typedef logic [7:0] byte_t;

    function automatic byte_t prot_addr(input int idx);
        case (idx)
            0:       return 8'h1C;
            1:       return 8'h20;
            2:       return 8'h21;
            3:       return 8'h26;
            4:       return 8'h27;
            default: return 8'h30;
        endcase
    endfunction

    function automatic byte_t prot_code(input int idx);
        return (idx == IDX_OSC) ? CODE_OSC : CODE_SYS;
    endfunction

    function automatic byte_t prot_rst(input int idx);
        case (idx)
            IDX_THRESH: return 8'hF0;
            IDX_BKUP:   return 8'h80;
            default:    return 8'h00;
        endcase
    endfunction

    typedef struct packed {
        byte_t key;
    } key_state_t;

    typedef struct packed {
        byte_t rdata;
    } rd_state_t;

endpackage

// File: rtl/cfgk_key_unit.sv
module cfgk_key_unit
    import cfgk_pkg::*;
#(
    parameter int NP = NUM_PROT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [7:0]    addr,
    input  logic [7:0]    wdata,
    output logic [NP-1:0] grant,
    output logic [7:0]    key_val
);

    key_state_t st_d, st_q;
    logic [NP-1:0] hit;

    for (genvar i = 0; i < NP; i++) begin : g_cmp
        assign hit[i]   = wr && (addr == prot_addr(i));
        assign grant[i] = hit[i] && (st_q.key == prot_code(i));
    end

    always_comb begin
        st_d = st_q;
        if (wr && addr == KEY_ADDR) begin
            if (wdata == CODE_OSC || wdata == CODE_SYS)
                st_d.key = wdata;
            else
                st_d.key = 8'h00;
        end else if (|grant) begin
            st_d.key = 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign key_val = st_q.key;

endmodule

// File: rtl/cfgk_prot_bank.sv
module cfgk_prot_bank
    import cfgk_pkg::*;
#(
    parameter int NP = NUM_PROT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NP-1:0]       grant,
    input  logic [7:0]          wdata,
    output logic [NP-1:0][7:0]  regs
);

    logic [NP-1:0][7:0] regs_d, regs_q;

    for (genvar i = 0; i < NP; i++) begin : g_reg
        always_comb begin
            regs_d[i] = regs_q[i];
            if (grant[i]) regs_d[i] = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[i] <= prot_rst(i);
            else        regs_q[i] <= regs_d[i];
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/cfgk_plain_bank.sv
module cfgk_plain_bank #(
    parameter int NUM_PLAIN = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [7:0]                 addr,
    input  logic [7:0]                 wdata,
    output logic [NUM_PLAIN-1:0][7:0]  regs
);

    logic [NUM_PLAIN-1:0][7:0] regs_d, regs_q;

    for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_reg
        always_comb begin
            regs_d[i] = regs_q[i];
            if (wr && addr == 8'(i)) regs_d[i] = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[i] <= 8'h00;
            else        regs_q[i] <= regs_d[i];
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/cfgk_regfile.sv
module cfgk_regfile
    import cfgk_pkg::*;
#(
    parameter int NUM_PLAIN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_wr,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata,
    output logic       osc_rc_autoswitch,
    output logic [3:0] sw_threshold,
    output logic       backup_bus_en
);

    logic [NUM_PROT-1:0]        grant;
    logic [7:0]                 key_val;
    logic [NUM_PROT-1:0][7:0]   prot_regs;
    logic [NUM_PLAIN-1:0][7:0]  plain_regs;
    logic [7:0]                 rd_val;
    rd_state_t                  rd_d, rd_q;

    cfgk_key_unit #(.NP(NUM_PROT)) i_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .grant   (grant),
        .key_val (key_val)
    );

    cfgk_prot_bank #(.NP(NUM_PROT)) i_prot (
        .clk   (clk),
        .rst_n (rst_n),
        .grant (grant),
        .wdata (bus_wdata),
        .regs  (prot_regs)
    );

    cfgk_plain_bank #(.NUM_PLAIN(NUM_PLAIN)) i_plain (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .regs  (plain_regs)
    );

    always_comb begin
        rd_val = 8'h00;
        for (int i = 0; i < NUM_PLAIN; i++)
            if (bus_addr == 8'(i)) rd_val = plain_regs[i];
        for (int j = 0; j < NUM_PROT; j++)
            if (bus_addr == prot_addr(j)) rd_val = prot_regs[j];
    end

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) rd_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata         = rd_q.rdata;
    assign osc_rc_autoswitch = prot_regs[IDX_OSC][4];
    assign sw_threshold      = prot_regs[IDX_THRESH][7:4];
    assign backup_bus_en     = prot_regs[IDX_BKUP][7];

endmodule

// File: rtl/cfgk_checker.sv
module cfgk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       osc_rc_autoswitch,
    input logic [3:0] sw_threshold,
    input logic       backup_bus_en,
    input logic [7:0] key_val
);

    logic sys_hit;
    assign sys_hit = bus_wr && (bus_addr == 8'h20 || bus_addr == 8'h21 || bus_addr == 8'h26 ||
                                bus_addr == 8'h27 || bus_addr == 8'h30);

    // R2
    osc_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 8'h1C && key_val == 8'hA1) |=> $stable(osc_rc_autoswitch));

    // R3
    thresh_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 8'h21 && key_val == 8'h9D) |=> $stable(sw_threshold));

    // R3
    bkup_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 8'h27 && key_val == 8'h9D) |=> $stable(backup_bus_en));

    // R4
    key_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr && bus_addr == 8'h1C && key_val == 8'hA1) || (sys_hit && key_val == 8'h9D))
        |=> key_val == 8'h00);

    // R5
    key_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr && bus_addr == 8'h1C && key_val != 8'hA1) || (sys_hit && key_val != 8'h9D))
        |=> $stable(key_val));

    // R6
    key_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h1F && bus_wdata != 8'hA1 && bus_wdata != 8'h9D)
        |=> key_val == 8'h00);

    // R8
    plain_keeps_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr < 8'h10) |=> $stable(key_val));

    // R7
    key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h1F) |=> bus_rdata == 8'h00);

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R6
    always @(posedge clk)
        if (rst_n)
            key_legal_chk: assert (key_val == 8'h00 || key_val == 8'hA1 || key_val == 8'h9D);

endmodule

bind cfgk_regfile cfgk_checker i_cfgk_checker (
    .clk               (clk),
    .rst_n             (rst_n),
    .bus_addr          (bus_addr),
    .bus_wdata         (bus_wdata),
    .bus_wr            (bus_wr),
    .bus_rd            (bus_rd),
    .bus_rdata         (bus_rdata),
    .osc_rc_autoswitch (osc_rc_autoswitch),
    .sw_threshold      (sw_threshold),
    .backup_bus_en     (backup_bus_en),
    .key_val           (key_val)
);

// File: tb/test_cfgk_regfile.sv
module test_cfgk_regfile;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       osc_rc_autoswitch;
    logic [3:0] sw_threshold;
    logic       backup_bus_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfgk_regfile i_cfgk_regfile (
        .clk               (clk),
        .rst_n             (rst_n),
        .bus_addr          (bus_addr),
        .bus_wdata         (bus_wdata),
        .bus_wr            (bus_wr),
        .bus_rd            (bus_rd),
        .bus_rdata         (bus_rdata),
        .osc_rc_autoswitch (osc_rc_autoswitch),
        .sw_threshold      (sw_threshold),
        .backup_bus_en     (backup_bus_en)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        check("R1 osc port", {7'd0, osc_rc_autoswitch}, 8'h00);
        check("R1 threshold port", {4'd0, sw_threshold}, 8'h0F);
        check("R1 backup port", {7'd0, backup_bus_en}, 8'h01);
        expect_reg("R1 reg 1C", 8'h1C, 8'h00);
        expect_reg("R1 reg 20", 8'h20, 8'h00);
        expect_reg("R1 reg 21", 8'h21, 8'hF0);
        expect_reg("R1 reg 26", 8'h26, 8'h00);
        expect_reg("R1 reg 27", 8'h27, 8'h80);
        expect_reg("R1 reg 30", 8'h30, 8'h00);
    endtask

    task automatic t_osc_unlock;
        wr(8'h1C, 8'h10);
        expect_reg("R2 no key", 8'h1C, 8'h00);
        wr(8'h1F, 8'h9D);
        wr(8'h1C, 8'h10);
        expect_reg("R2 wrong code", 8'h1C, 8'h00);
        wr(8'h20, 8'h5A);
        expect_reg("R5 key kept after reject", 8'h20, 8'h5A);
        wr(8'h1F, 8'hA1);
        wr(8'h1C, 8'h10);
        expect_reg("R2 unlocked", 8'h1C, 8'h10);
        check("R10 osc port", {7'd0, osc_rc_autoswitch}, 8'h01);
        wr(8'h1C, 8'h00);
        expect_reg("R4 second write ignored", 8'h1C, 8'h10);
    endtask

    task automatic t_sys_unlock;
        logic [7:0] addrs [5] = '{8'h20, 8'h21, 8'h26, 8'h27, 8'h30};
        for (int i = 0; i < 5; i++) begin
            wr(8'h1F, 8'h9D);
            wr(addrs[i], 8'h31 + 8'(i));
            expect_reg("R3 unlocked write", addrs[i], 8'h31 + 8'(i));
            wr(addrs[i], 8'hEE);
            expect_reg("R4 relock", addrs[i], 8'h31 + 8'(i));
        end
        check("R10 threshold port", {4'd0, sw_threshold}, 8'h03);
        check("R10 backup port", {7'd0, backup_bus_en}, 8'h00);
        wr(8'h1F, 8'hA1);
        wr(8'h26, 8'hC3);
        expect_reg("R3 osc code rejected", 8'h26, 8'h33);
        wr(8'h1C, 8'h00);
        expect_reg("R5 osc code kept", 8'h1C, 8'h00);
        check("R10 osc port cleared", {7'd0, osc_rc_autoswitch}, 8'h00);
    endtask

    task automatic t_key_clear;
        wr(8'h1F, 8'h9D);
        wr(8'h1F, 8'h55);
        wr(8'h30, 8'hAA);
        expect_reg("R6 bad code clears", 8'h30, 8'h35);
        wr(8'h1F, 8'h9D);
        wr(8'h1F, 8'hA1);
        wr(8'h30, 8'hAA);
        expect_reg("R6 code replaced", 8'h30, 8'h35);
        wr(8'h1C, 8'h10);
        expect_reg("R6 new code held", 8'h1C, 8'h10);
    endtask

    task automatic t_key_read;
        wr(8'h1F, 8'h9D);
        expect_reg("R7 key reads zero", 8'h1F, 8'h00);
        wr(8'h21, 8'hA0);
        expect_reg("R7 read kept key", 8'h21, 8'hA0);
    endtask

    task automatic t_plain;
        wr(8'h03, 8'h77);
        expect_reg("R8 plain no key", 8'h03, 8'h77);
        wr(8'h1F, 8'h9D);
        wr(8'h0F, 8'h12);
        wr(8'h00, 8'h34);
        expect_reg("R8 plain top", 8'h0F, 8'h12);
        expect_reg("R8 plain bottom", 8'h00, 8'h34);
        wr(8'h27, 8'h81);
        expect_reg("R8 key not consumed", 8'h27, 8'h81);
        check("R10 backup port set", {7'd0, backup_bus_en}, 8'h01);
    endtask

    task automatic t_read_path;
        logic [7:0] v;
        expect_reg("R9 unmapped 40", 8'h40, 8'h00);
        expect_reg("R9 unmapped 10", 8'h10, 8'h00);
        rd(8'h21, v);
        check("R9 read 21", v, 8'hA0);
        wr(8'h03, 8'h99);
        @(negedge clk);
        bus_addr = 8'h03;
        repeat (3) @(negedge clk);
        check("R9 hold without strobe", bus_rdata, 8'hA0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_osc_unlock();
        t_sys_unlock();
        t_key_clear();
        t_key_read();
        t_plain();
        t_read_path();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule